// File: doc/BRIEF.md
# Register-Stack RAM with Output Register

A 16-word by 4-bit read/write store. Its read path ends in a 4-bit output register that loads on the rising clock edge. A write is level-sensitive. The addressed word is open to the data inputs for the whole low phase of the clock, as long as chip select and write enable are also low. While this happens, the output register keeps the word captured at the last rising edge. A new word can therefore be written while the previous result stays on the outputs, which suits register-stack use.

The output is presented as a 4-bit data value plus a drive-enable flag. The drive enable follows the active-low output-enable input. A pad ring or bus wrapper uses that flag to put the lines in high impedance. The block has no reset: the array and the output register hold unknown values until they are written or loaded.

Top module: `regstack_ram`

## Requirements
- R1: The array holds 16 independent 4-bit words, selected by a 4-bit address, and a word written at one address does not disturb any other address.
- R2: A word is written only while `csN`, `weN` and `clk` are all low, and a low phase with `csN` high or `weN` high leaves the array unchanged.
- R3: While the write condition holds, the addressed word follows `dataIn`, so the array keeps the value present at the end of the low phase.
- R4: When `csN` is low at a rising edge of `clk`, `qData` takes the word stored at `addr`. This includes a word written in the low phase just before that edge.
- R5: `qData` does not change during the low phase of the clock, including while a write is active.
- R6: When `csN` is high at a rising edge, `qData` keeps its previous value.
- R7: `qDrive` is 1 while `oeN` is low and 0 while `oeN` is high, which stands for the high-impedance state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock: low phase opens writes, rising edge loads the output register |
| addr | input | 4 | Word address |
| dataIn | input | 4 | Write data |
| csN | input | 1 | Chip select, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| qData | output | 4 | Output register contents |
| qDrive | output | 1 | 1 when the outputs are driven, 0 for high impedance |

## Verification
The transparency check assumes that `addr` and the write controls stay still for the whole clock-low phase, and that only `dataIn` may move inside it. The stimulus meets this by changing the address and the controls only just after a rising edge, while the clock is high. Data is changed a second time only in the middle of the low phase. The assertions also assume the array is read only after it has been written. The random stimulus starts from unknown contents, and the reference model marks each word as unknown until it is written, so a read is compared only after a write has defined it.

// File: rtl/regstack_pkg.sv
package regstack_pkg;
  // Strobes passed from the control decoder to the datapath
  typedef struct packed {
    logic writeOpen;   // level: array cell transparent
    logic captureEn;   // sampled at rising edge: load output register
    logic driveEn;     // outputs driven
  } rsStrobe_t;
endpackage

// File: rtl/regstack_ctrl.sv
module regstack_ctrl
  import regstack_pkg::*;
(
  input  logic       clk,
  input  logic       csN,
  input  logic       weN,
  input  logic       oeN,
  output rsStrobe_t  strobe
);
  always_comb begin
    strobe.writeOpen = ~clk & ~csN & ~weN;
    strobe.captureEn = ~csN;
    strobe.driveEn   = ~oeN;
  end

  // R2: a write window can only exist during the clock-low phase
  always_comb begin
    if (clk) a_no_write_high_r2: assert (!strobe.writeOpen);
  end
endmodule

// File: rtl/regstack_datapath.sv
module regstack_datapath
  import regstack_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  rsStrobe_t         strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] qData,
  output logic              qDrive
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdWord;
  logic [DATA_W-1:0] qReg;

  // Level-sensitive storage: the selected word is open while writeOpen holds
  always_latch begin
    for (int w = 0; w < DEPTH; w++) begin
      if (strobe.writeOpen && (addr == ADDR_W'(w))) mem[w] <= dataIn;
    end
  end

  assign rdWord = mem[addr];

  // Output register, loaded at the rising edge when selected
  always_ff @(posedge clk) begin
    if (strobe.captureEn) qReg <= rdWord;
  end

  assign qData  = qReg;
  assign qDrive = strobe.driveEn;

  logic pastValid = 1'b0;
  always_ff @(posedge clk) pastValid <= 1'b1;

  // R3: just before the edge, an open cell mirrors the data inputs
  p_transparent_r3: assert property (@(posedge clk) disable iff (!pastValid)
    strobe.writeOpen |-> (mem[addr] == dataIn));

  // R4: a selected edge loads the word seen at that edge
  p_capture_word_r4: assert property (@(posedge clk) disable iff (!pastValid)
    strobe.captureEn |=> (qReg == $past(rdWord)));

  // R6: a deselected edge keeps the output register
  p_hold_deselected_r6: assert property (@(posedge clk) disable iff (!pastValid)
    !strobe.captureEn |=> $stable(qReg));
endmodule

// File: rtl/regstack_ram.sv
module regstack_ram
  import regstack_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              csN,
  input  logic              weN,
  input  logic              oeN,
  output logic [DATA_W-1:0] qData,
  output logic              qDrive
);
  rsStrobe_t strobe;

  regstack_ctrl ctrl_i (
    .clk    (clk),
    .csN    (csN),
    .weN    (weN),
    .oeN    (oeN),
    .strobe (strobe)
  );

  regstack_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk    (clk),
    .strobe (strobe),
    .addr   (addr),
    .dataIn (dataIn),
    .qData  (qData),
    .qDrive (qDrive)
  );

  // R7: drive flag from the datapath tracks the output-enable pin
  always_comb begin
    a_drive_oe_r7: assert (qDrive == !oeN);
  end
endmodule

// File: tb/regstack_ram_tb.sv
module regstack_ram_tb_top;
  logic       clk = 1'b0;
  logic [3:0] addr = '0;
  logic [3:0] dataIn = '0;
  logic       csN = 1'b1;
  logic       weN = 1'b1;
  logic       oeN = 1'b1;
  logic [3:0] qData;
  logic       qDrive;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [3:0] model [16];
  bit         known [16];
  logic [3:0] qModel = '0;
  bit         qKnown = 0;

  always #4 clk = ~clk;  // 125 MHz

  regstack_ram dut_i (
    .clk(clk), .addr(addr), .dataIn(dataIn), .csN(csN), .weN(weN),
    .oeN(oeN), .qData(qData), .qDrive(qDrive)
  );

  function automatic bit expDrive(input logic oe);
    return !oe;
  endfunction

  task automatic check4(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock cycle: inputs set while clk high, optional mid-low data change
  task automatic cycle(input logic [3:0] a, input logic [3:0] d, input logic cs,
                       input logic we, input logic oe, input bit chg,
                       input logic [3:0] d2);
    logic [3:0] fin;
    @(posedge clk); #1;
    addr = a; dataIn = d; csN = cs; weN = we; oeN = oe;
    @(negedge clk); #2;
    // R5: output register unchanged during low phase (also while writing)
    if (qKnown) check4("R5", qData, qModel);
    check4("R7", {3'b0, qDrive}, {3'b0, expDrive(oe)});
    fin = d;
    if (chg) begin dataIn = d2; fin = d2; end
    @(posedge clk);
    if (!cs && !we) begin model[a] = fin; known[a] = 1; end  // R2/R3
    if (!cs) begin qModel = model[a]; qKnown = known[a]; end // R4, R6 otherwise
    #2;
    if (qKnown) check4(cs ? "R6" : "R4", qData, qModel);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin known[i] = 0; model[i] = '0; end
    // Reset-free start: outputs disabled report no drive
    #2; check4("R7", {3'b0, qDrive}, 4'h0);
    // R1: fill every address with a distinct pattern, then read back
    for (int i = 0; i < 16; i++) cycle(4'(i), 4'(15 - i), 0, 0, 1, 0, 0);
    for (int i = 0; i < 16; i++) cycle(4'(i), 4'h0, 0, 1, 0, 0, 0);
    // R2: write enable high and chip select high leave the word untouched
    cycle(4'h3, 4'h5, 0, 1, 0, 0, 0);
    cycle(4'h3, 4'hA, 1, 0, 0, 0, 0);
    cycle(4'h3, 4'h0, 0, 1, 0, 0, 0);
    // R3: data moved mid low phase, final value kept and captured
    cycle(4'h7, 4'h1, 0, 0, 0, 1, 4'hE);
    cycle(4'h7, 4'h0, 0, 1, 0, 0, 0);
    // R6: deselected edges hold the register
    cycle(4'h9, 4'h0, 1, 1, 0, 0, 0);
    cycle(4'h2, 4'h0, 1, 1, 0, 0, 0);
    // R7: output disabled then enabled
    cycle(4'h2, 4'h0, 0, 1, 1, 0, 0);
    cycle(4'h2, 4'h0, 0, 1, 0, 0, 0);
    // Random mix, fixed seed
    void'($urandom(32'd1234));
    for (int n = 0; n < 3000; n++) begin
      cycle(4'($urandom), 4'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), 4'($urandom));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule